// File: doc/BRIEF.md
# Fuse-Programmable AND-OR Logic Array

This block models a small combinational programmable logic device. It has sixteen array input columns: ten dedicated inputs, plus six columns that are fed back from output pins. It drives eight active-low outputs, and each output has its own enable signal. Each output owns a block of eight product-term rows. The first row of the block decides whether the output is enabled. The remaining seven rows are OR-ed together and inverted to form the output level. Every row is a 32-bit fuse word holding sixteen two-bit literal selectors, one per input column.

The 2048-bit fuse map is loaded serially, one bit per accepted configuration cycle, starting at fuse address 0. Once the last bit has arrived the map is frozen. From then on the outputs follow the inputs combinationally, and feedback columns see the settled output value from the previous clock. A pin's state is modelled as a data output and a separate enable output rather than a real tri-state driver. Feedback from a disabled output comes from the external level presented on that pin.

Top module: `fuse_logic_array`

## Requirements
- R1: After reset, `cfgDone` is 0, `outEn` is all zeros and `outN` is all ones.
- R2: Each cycle with `cfgValid` high stores `cfgBit` at the next fuse address. The first accepted bit goes to address 0. Address a belongs to row a/32 and bit a%32 of that row. `cfgDone` is 0 after 2047 accepted bits and 1 from the clock edge that accepts the 2048th bit.
- R3: Once `cfgDone` is 1, further `cfgValid` pulses leave the fuse map unchanged, so outputs for a given input vector do not change.
- R4: While `cfgDone` is 0, `outEn` stays all zeros and `outN` all ones, whatever the inputs.
- R5: Within a row, pair p occupies bits 2p (true literal) and 2p+1 (complement literal). A fuse value of 1 means removed and 0 means connected. Pair 11 ignores the column, 10 needs the column to be 0, and 01 needs it to be 1. A row is true when all of its connected literals are 1.
- R6: A row whose 32 bits are all 0 is never true. An output with all seven sum rows at 0 drives `outN`=1, and an all-zero enable row keeps `outEn`=0.
- R7: Output j (bit j of `outN`/`outEn`, pin 19-j) owns rows 8j to 8j+7. Row 8j is its enable term, so `outEn[j]` equals that row.
- R8: Pairs 0 to 15 read pins 2,1,3,18,4,17,5,16,6,15,7,14,8,13,9,11. `dedIn[n-1]` is pin n for n=1..9, and `dedIn[9]` is pin 11. Pin 19-j for j=1..6 is a feedback column.
- R9: When output j (1..6) is enabled, its feedback column reads that output's value from the previous clock. When it is disabled, the column reads `fbPinIn[j-1]`.
- R10: `outN[j]` is the inverse of the OR of rows 8j+1 to 8j+7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Configuration bit strobe |
| cfgBit | input | 1 | Serial fuse bit |
| cfgDone | output | 1 | Fuse map fully loaded |
| dedIn | input | 10 | Dedicated inputs (pins 1-9, 11) |
| fbPinIn | input | 6 | External level on pins 18..13 |
| outN | output | 8 | Active-low outputs, bit j is pin 19-j |
| outEn | output | 8 | Output enable, bit j is pin 19-j |

## Verification
The embedded assertions check the loading rules on every cycle:
- The bit counter never passes the map size.
- `cfgDone` only rises right after an accepted bit and never falls again.
- The fuse map stays frozen once loaded.
- No output is enabled before loading completes.

The literal encoding, the column order, the enable-row placement, the all-zero-row rule and the feedback source selection can only be shown by the bench. It loads specific fuse maps and compares the outputs against an independent model of the array over many input vectors.

// File: rtl/fla_pkg.sv
package fla_pkg;
  localparam int PAIRS        = 16;
  localparam int ROW_BITS     = 2 * PAIRS;
  localparam int ROWS_PER_OUT = 8;
  localparam int OUTS         = 8;
  localparam int ROWS         = ROWS_PER_OUT * OUTS;
  localparam int FUSES        = ROWS * ROW_BITS;
  localparam int DED          = 10;
  localparam int FB           = 6;

  typedef struct packed {
    logic shiftEn;
    logic loaded;
  } fla_strobe_t;
endpackage

// File: rtl/fla_cfg_ctrl.sv
module fla_cfg_ctrl
  import fla_pkg::*;
#(
  parameter int NFUSE = FUSES
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgValid,
  output fla_strobe_t strb
);
  localparam int CNT_W = $clog2(NFUSE + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NFUSE);

  logic [CNT_W-1:0] bitCnt;
  logic             full;

  assign full         = (bitCnt == LAST);
  assign strb.loaded  = full;
  assign strb.shiftEn = cfgValid && !full;

  always_ff @(posedge clk) begin
    if (!rstN)             bitCnt <= '0;
    else if (strb.shiftEn) bitCnt <= bitCnt + 1'b1;
  end

  // R2: counter never runs past the map size
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST);
  // R2: completion appears only right after an accepted bit
  p_done_after_shift_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.loaded) |-> $past(strb.shiftEn));
  // R3: completion is sticky
  p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loaded |=> strb.loaded);
endmodule

// File: rtl/fla_array_dp.sv
module fla_array_dp
  import fla_pkg::*;
#(
  parameter int NOUT  = OUTS,
  parameter int RPO   = ROWS_PER_OUT,
  parameter int NPAIR = PAIRS
) (
  input  logic              clk,
  input  logic              rstN,
  input  fla_strobe_t       strb,
  input  logic              cfgBit,
  input  logic [DED-1:0]    dedIn,
  input  logic [FB-1:0]     fbPinIn,
  output logic [NOUT-1:0]   outN,
  output logic [NOUT-1:0]   outEn
);
  localparam int RBITS = 2 * NPAIR;
  localparam int NROW  = NOUT * RPO;
  localparam int NFUSE = NROW * RBITS;

  logic [NFUSE-1:0] fuseMap;
  logic [NOUT-1:0]  outQ, enQ;
  logic [FB-1:0]    fbSel;
  logic [NPAIR-1:0] lit;
  logic [RBITS-1:0] litVec;
  logic [NROW-1:0]  rowTrue;
  logic [NOUT-1:0]  enTerm, sumOr;

  // Serial fill: first bit ends up at address 0 after the final shift
  always_ff @(posedge clk) begin
    if (!rstN)             fuseMap <= '0;
    else if (strb.shiftEn) fuseMap <= {cfgBit, fuseMap[NFUSE-1:1]};
  end

  // Settle stage for feedback columns
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outQ <= '1;
      enQ  <= '0;
    end else begin
      outQ <= outN;
      enQ  <= outEn;
    end
  end

  for (genvar k = 0; k < FB; k++) begin : g_fb
    assign fbSel[k] = enQ[k+1] ? outQ[k+1] : fbPinIn[k];
  end

  // Interleaved column order: even pairs walk pins 2..9, odd pairs
  // take pin 1, the six feedback pins, then pin 11.
  for (genvar p = 0; p < NPAIR; p++) begin : g_col
    if (p % 2 == 0) begin : g_even
      assign lit[p] = dedIn[p/2 + 1];
    end else if (p == 1) begin : g_first
      assign lit[p] = dedIn[0];
    end else if (p == NPAIR - 1) begin : g_last
      assign lit[p] = dedIn[DED-1];
    end else begin : g_fbcol
      assign lit[p] = fbSel[(p-3)/2];
    end
    assign litVec[2*p]   = lit[p];
    assign litVec[2*p+1] = ~lit[p];
  end

  for (genvar r = 0; r < NROW; r++) begin : g_row
    assign rowTrue[r] = &(fuseMap[r*RBITS +: RBITS] | litVec);
  end

  for (genvar j = 0; j < NOUT; j++) begin : g_out
    assign enTerm[j] = rowTrue[j*RPO];
    assign sumOr[j]  = |rowTrue[j*RPO+1 +: RPO-1];
  end

  assign outN  = strb.loaded ? ~sumOr : '1;
  assign outEn = strb.loaded ? enTerm : '0;

  // R3: map frozen after loading
  p_map_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loaded |=> $stable(fuseMap));
  // R4: no enable before the map is complete
  p_hold_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|enQ) |-> $past(strb.loaded));
endmodule

// File: rtl/fuse_logic_array.sv
module fuse_logic_array
  import fla_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgValid,
  input  logic            cfgBit,
  output logic            cfgDone,
  input  logic [DED-1:0]  dedIn,
  input  logic [FB-1:0]   fbPinIn,
  output logic [OUTS-1:0] outN,
  output logic [OUTS-1:0] outEn
);
  fla_strobe_t strb;

  fla_cfg_ctrl #(.NFUSE(FUSES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .strb(strb)
  );

  fla_array_dp #(.NOUT(OUTS), .RPO(ROWS_PER_OUT), .NPAIR(PAIRS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgBit(cfgBit),
    .dedIn(dedIn), .fbPinIn(fbPinIn), .outN(outN), .outEn(outEn)
  );

  assign cfgDone = strb.loaded;

  // R4: an enabled output implies a complete map
  p_enable_needs_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|outEn) |-> cfgDone);
endmodule

// File: tb/sim_fuse_logic_array.sv
module sim_fuse_logic_array;
  logic clk = 0, rstN = 0, cfgValid = 0, cfgBit = 0, cfgDone;
  logic [9:0] dedIn = '0;
  logic [5:0] fbPinIn = '0;
  logic [7:0] outN, outEn;
  int checks = 0, errors = 0;
  bit fz[2048];

  typedef struct { logic [7:0] n; logic [7:0] e; string tag; } exp_t;
  exp_t q[$];
  event sampleEv;

  always #4 clk = ~clk;

  fuse_logic_array u0 (.clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgBit(cfgBit),
    .cfgDone(cfgDone), .dedIn(dedIn), .fbPinIn(fbPinIn), .outN(outN), .outEn(outEn));

  function automatic int colPin(int p);
    case (p)
      0: return 2;   1: return 1;   2: return 3;   3: return 18;
      4: return 4;   5: return 17;  6: return 5;   7: return 16;
      8: return 6;   9: return 15;  10: return 7;  11: return 14;
      12: return 8;  13: return 13; 14: return 9;  default: return 11;
    endcase
  endfunction

  function automatic int pairOf(int pin);
    for (int p = 0; p < 16; p++) if (colPin(p) == pin) return p;
    return 0;
  endfunction

  function automatic logic pinVal(int pin, logic [9:0] d, logic [5:0] fp,
                                  logic [7:0] pn, logic [7:0] pe);
    int j;
    if (pin <= 9) return d[pin-1];
    if (pin == 11) return d[9];
    j = 19 - pin;
    return pe[j] ? pn[j] : fp[j-1];
  endfunction

  function automatic logic rowEval(int r, logic [9:0] d, logic [5:0] fp,
                                   logic [7:0] pn, logic [7:0] pe);
    logic res = 1;
    for (int p = 0; p < 16; p++) begin
      logic v = pinVal(colPin(p), d, fp, pn, pe);
      if (!fz[r*32+2*p]   && !v) res = 0;
      if (!fz[r*32+2*p+1] &&  v) res = 0;
    end
    return res;
  endfunction

  task automatic model(input logic [9:0] d, input logic [5:0] fp,
                       output logic [7:0] n, output logic [7:0] e);
    logic [7:0] pn = '1, pe = '0, nn, ne;
    for (int it = 0; it < 10; it++) begin
      for (int j = 0; j < 8; j++) begin
        logic s = 0;
        ne[j] = rowEval(8*j, d, fp, pn, pe);
        for (int k = 1; k < 8; k++) s |= rowEval(8*j+k, d, fp, pn, pe);
        nn[j] = ~s;
      end
      pn = nn; pe = ne;
    end
    n = pn; e = pe;
  endtask

  task automatic check(logic [31:0] got, logic [31:0] exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Monitor: pops expected items and compares them with the design outputs
  initial forever begin
    exp_t x;
    @(sampleEv);
    x = q.pop_front();
    check({24'd0, outN}, {24'd0, x.n}, {x.tag, " outN"});
    check({24'd0, outEn}, {24'd0, x.e}, {x.tag, " outEn"});
  end

  task automatic applyVec(logic [9:0] d, logic [5:0] fp, string tag, bit loaded);
    exp_t x;
    @(negedge clk);
    dedIn = d; fbPinIn = fp;
    repeat (4) @(negedge clk);
    if (loaded) model(d, fp, x.n, x.e);
    else begin x.n = '1; x.e = '0; end
    x.tag = tag;
    q.push_back(x);
    ->sampleEv;
    #1;
  endtask

  task automatic rowSet(int r, bit v);
    for (int b = 0; b < 32; b++) fz[r*32+b] = v;
  endtask

  task automatic litSet(int r, int pin, bit v);
    int p = pairOf(pin);
    fz[r*32+2*p]   = v ? 1'b0 : 1'b1;
    fz[r*32+2*p+1] = v ? 1'b1 : 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0; cfgValid = 0;
    repeat (2) @(negedge clk); rstN = 1;
  endtask

  task automatic loadMap(bit midCheck);
    for (int a = 0; a < 2048; a++) begin
      @(negedge clk);
      if (a == 2047) check({31'd0, cfgDone}, 32'd0, "R2 done after 2047 bits");
      if (midCheck && a == 1000) begin
        check({24'd0, outEn}, 32'd0, "R4 outEn during load");
        check({24'd0, outN}, 32'hFF, "R4 outN during load");
      end
      cfgValid = 1; cfgBit = fz[a];
    end
    @(negedge clk); cfgValid = 0;
    check({31'd0, cfgDone}, 32'd1, "R2 done after 2048 bits");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    check({31'd0, cfgDone}, 32'd0, "R1 cfgDone");
    check({24'd0, outEn}, 32'd0, "R1 outEn");
    check({24'd0, outN}, 32'hFF, "R1 outN");
    applyVec(10'h3FF, 6'h3F, "R4 before load", 0);

    // Program A: exercises R5 R6 R7 R8 R9 R10
    for (int r = 0; r < 64; r++) rowSet(r, 0);
    rowSet(0, 1); rowSet(1, 1); litSet(1, 2, 1); litSet(1, 3, 0);
    rowSet(2, 1); litSet(2, 4, 1);
    rowSet(8, 1); litSet(8, 1, 0);
    rowSet(9, 1); litSet(9, 5, 1); litSet(9, 6, 1);
    rowSet(17, 1); litSet(17, 7, 1);
    rowSet(24, 1); rowSet(25, 1); litSet(25, 18, 0);
    rowSet(32, 1);
    rowSet(40, 1); rowSet(41, 1); litSet(41, 11, 1);
    rowSet(42, 1); litSet(42, 9, 0); litSet(42, 8, 1);
    rowSet(48, 1); rowSet(49, 1); litSet(49, 17, 1);
    rowSet(56, 1); litSet(56, 2, 1); rowSet(57, 1); litSet(57, 16, 1);
    loadMap(1);

    for (int i = 0; i < 40; i++) begin
      logic [9:0] d = 10'((i * 397) ^ (i << 4) ^ (i >> 1));
      logic [5:0] fp = 6'((i * 11) ^ (i >> 2));
      applyVec(d, fp, "R5 R7 R8 R9 R10 vector", 1);
    end
    applyVec(10'h000, 6'h00, "R9 feedback enabled pin1 low", 1);
    applyVec(10'h001, 6'h00, "R9 feedback from pin pin1 high", 1);
    applyVec(10'h001, 6'h01, "R9 feedback from pin pin1 high", 1);

    // R3: bits after completion are ignored
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); cfgValid = 1; cfgBit = i[0] ^ i[3];
    end
    @(negedge clk); cfgValid = 0;
    for (int i = 0; i < 8; i++)
      applyVec(10'(i * 131), 6'(i * 7), "R3 map unchanged", 1);

    // Program B: every pair don't care, all rows true
    doReset();
    for (int r = 0; r < 64; r++) rowSet(r, 1);
    loadMap(0);
    applyVec(10'h155, 6'h2A, "R5 all dont-care", 1);
    check({24'd0, outEn}, 32'hFF, "R5 R7 all enabled");
    check({24'd0, outN}, 32'h00, "R5 R10 all low");

    // Program C: every row all zero, never true
    doReset();
    for (int r = 0; r < 64; r++) rowSet(r, 0);
    loadMap(0);
    applyVec(10'h3FF, 6'h3F, "R6 zero rows", 1);
    check({24'd0, outEn}, 32'h00, "R6 no enable");
    check({24'd0, outN}, 32'hFF, "R6 outputs high");

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule